// File: doc/BRIEF.md
# Bracket Match Scan Controller

This block steers the program counter of a small tape-machine interpreter around its two loop instructions, the loop-open and the loop-close bracket. When a loop must be skipped (open bracket on a zero cell) or repeated (close bracket on a non-zero cell), the block enters a scan mode. In that mode every instruction fetched is passed over rather than executed, and the program counter walks forward or backward until the bracket that pairs with the starting one is reached.

Pairing is found with an 8-bit nesting depth counter. Brackets crossed during the scan raise or lower the count, and the count reading zero marks the next bracket in the scan direction as the partner. Two flags record whether a scan is running and whether it runs backward. One command is accepted per cycle. All results appear as registered single-cycle requests one cycle after the command: step the program counter up or down, and count the depth up or down. The flags and the depth value are also presented as outputs.

Top module: `bracket_scan_ctrl`

## Requirements
- R1: After a synchronous reset, every request output is 0, `scan_active` and `scan_back` are 0, and `depth` is 0.
- R2: Command codes are 3 bits. The open bracket is code 6 and the close bracket is code 7. Outside a scan, an open bracket on a non-zero cell and a close bracket on a zero cell each give only `pc_inc`.
- R3: Outside a scan, an open bracket with `cell_zero`=1 gives `pc_inc` and sets `scan_active`, leaving `scan_back` at 0.
- R4: Outside a scan, a close bracket with `cell_zero`=0 gives `pc_dec` and sets both `scan_active` and `scan_back`.
- R5: In a forward scan, an open bracket gives `pc_inc` and `depth_up`. A close bracket with `depth` non-zero gives `pc_inc` and `depth_down`.
- R6: In a forward scan, a close bracket with `depth`=0 gives `pc_inc` and clears `scan_active`.
- R7: In a backward scan, a close bracket gives `pc_dec` and `depth_up`. An open bracket with `depth` non-zero gives `pc_dec` and `depth_down`.
- R8: In a backward scan, an open bracket with `depth`=0 gives `pc_inc` and clears both `scan_active` and `scan_back`. `scan_back` is never 1 while `scan_active` is 0.
- R9: During a scan, any code other than 6 or 7 gives only `pc_inc` when scanning forward, or only `pc_dec` when scanning backward. `cell_zero` is ignored throughout a scan.
- R10: Outside a scan, codes 0 to 5 give no request and leave flags and depth unchanged.
- R11: The depth counter wraps modulo 256: 256 open brackets in a forward scan return it to 0.
- R12: A cycle with `cmd_valid`=0 gives no request in the following cycle and leaves flags and depth unchanged. Requests last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 3 | Current command code |
| cell_zero | input | 1 | Current data cell holds zero |
| pc_inc | output | 1 | Request: step program counter up |
| pc_dec | output | 1 | Request: step program counter down |
| depth_up | output | 1 | Depth counter was raised this cycle |
| depth_down | output | 1 | Depth counter was lowered this cycle |
| scan_active | output | 1 | Scan mode flag |
| scan_back | output | 1 | Scan direction flag (1 = backward) |
| depth | output | 8 | Nesting depth count |

## Verification
A command presented before clock edge N has all of its effects visible after edge N. The requests, both flags and the depth value are due together, exactly one cycle after the stimulus. The bench's driver stamps every expected item with the cycle at which it falls due, and also queues items for idle cycles. The monitor compares only when the front item's stamp equals the current cycle, sampling on the falling edge. As a result, a late, early or lingering request is reported as a mismatch.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // one cycle of decided actions
  typedef struct packed {
    logic pc_up;
    logic pc_dn;
    logic dep_up;
    logic dep_dn;
    logic flip_scan;
    logic flip_dir;
  } bsc_act_t;

  localparam bsc_act_t BSC_ACT_NONE = '0;

endpackage

// File: rtl/bsc_decide.sv
module bsc_decide
  import bsc_pkg::*;
#(
  parameter int CMD_W      = 3,
  parameter int OPEN_CODE  = 6,
  parameter int CLOSE_CODE = 7
) (
  input  logic             valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic             cell_zero,
  input  logic             scan,
  input  logic             back,
  input  logic             matched,
  output bsc_act_t         act
);

  localparam logic [CMD_W-1:0] OPEN_C  = CMD_W'(OPEN_CODE);
  localparam logic [CMD_W-1:0] CLOSE_C = CMD_W'(CLOSE_CODE);

  logic is_open;
  logic is_close;

  assign is_open  = (cmd == OPEN_C);
  assign is_close = (cmd == CLOSE_C);

  always_comb begin
    act = BSC_ACT_NONE;
    if (valid) begin
      if (!scan) begin
        // normal execution: only brackets concern this block
        if (is_open) begin
          act.pc_up     = 1'b1;
          act.flip_scan = cell_zero;
        end else if (is_close) begin
          if (cell_zero) begin
            act.pc_up = 1'b1;
          end else begin
            act.pc_dn     = 1'b1;
            act.flip_scan = 1'b1;
            act.flip_dir  = 1'b1;
          end
        end
      end else if (!back) begin
        // forward scan
        if (is_open) begin
          act.pc_up  = 1'b1;
          act.dep_up = 1'b1;
        end else if (is_close) begin
          act.pc_up = 1'b1;
          if (matched) act.flip_scan = 1'b1;
          else         act.dep_dn    = 1'b1;
        end else begin
          act.pc_up = 1'b1;
        end
      end else begin
        // backward scan
        if (is_close) begin
          act.pc_dn  = 1'b1;
          act.dep_up = 1'b1;
        end else if (is_open) begin
          if (matched) begin
            act.pc_up     = 1'b1;
            act.flip_scan = 1'b1;
            act.flip_dir  = 1'b1;
          end else begin
            act.pc_dn  = 1'b1;
            act.dep_dn = 1'b1;
          end
        end else begin
          act.pc_dn = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bsc_flags.sv
module bsc_flags (
  input  logic clk,
  input  logic rst,
  input  logic flip_scan,
  input  logic flip_dir,
  output logic scan,
  output logic back
);

  always_ff @(posedge clk) begin
    if (rst) begin
      scan <= 1'b0;
      back <= 1'b0;
    end else begin
      scan <= scan ^ flip_scan;
      back <= back ^ flip_dir;
    end
  end

  AST_DIR_NEEDS_SCAN: assert property (@(posedge clk) disable iff (rst)
    back |-> scan); // R8

endmodule

// File: rtl/bsc_depth.sv
module bsc_depth #(
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up,
  input  logic               dn,
  output logic [DEPTH_W-1:0] depth,
  output logic               matched
);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
    end else if (up && !dn) begin
      depth <= depth + 1'b1;
    end else if (dn && !up) begin
      depth <= depth - 1'b1;
    end
  end

  assign matched = (depth == '0);

  AST_DEPTH_RAISE: assert property (@(posedge clk) disable iff (rst)
    (up && !dn) |=> (depth == DEPTH_W'($past(depth) + 1'b1))); // R11

  AST_DEPTH_LOWER: assert property (@(posedge clk) disable iff (rst)
    (dn && !up) |=> (depth == DEPTH_W'($past(depth) - 1'b1))); // R7

endmodule

// File: rtl/bracket_scan_ctrl.sv
module bracket_scan_ctrl
  import bsc_pkg::*;
#(
  parameter int CMD_W      = 3,
  parameter int DEPTH_W    = 8,
  parameter int OPEN_CODE  = 6,
  parameter int CLOSE_CODE = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_code,
  input  logic               cell_zero,
  output logic               pc_inc,
  output logic               pc_dec,
  output logic               depth_up,
  output logic               depth_down,
  output logic               scan_active,
  output logic               scan_back,
  output logic [DEPTH_W-1:0] depth
);

  bsc_act_t act;
  logic     scan_q;
  logic     back_q;
  logic     matched;

  bsc_decide #(
    .CMD_W      (CMD_W),
    .OPEN_CODE  (OPEN_CODE),
    .CLOSE_CODE (CLOSE_CODE)
  ) u_decide (
    .valid     (cmd_valid),
    .cmd       (cmd_code),
    .cell_zero (cell_zero),
    .scan      (scan_q),
    .back      (back_q),
    .matched   (matched),
    .act       (act)
  );

  bsc_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .flip_scan (act.flip_scan),
    .flip_dir  (act.flip_dir),
    .scan      (scan_q),
    .back      (back_q)
  );

  bsc_depth #(
    .DEPTH_W (DEPTH_W)
  ) u_depth (
    .clk     (clk),
    .rst     (rst),
    .up      (act.dep_up),
    .dn      (act.dep_dn),
    .depth   (depth),
    .matched (matched)
  );

  // registered request pulses, aligned with the flag and depth update
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_inc     <= 1'b0;
      pc_dec     <= 1'b0;
      depth_up   <= 1'b0;
      depth_down <= 1'b0;
    end else begin
      pc_inc     <= act.pc_up;
      pc_dec     <= act.pc_dn;
      depth_up   <= act.dep_up;
      depth_down <= act.dep_dn;
    end
  end

  assign scan_active = scan_q;
  assign scan_back   = back_q;

  AST_PC_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    !(pc_inc && pc_dec)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !(pc_inc || pc_dec || depth_up || depth_down)); // R12

  AST_DEPTH_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    (depth_up || depth_down) |-> scan_active); // R5

  AST_SCAN_MOVES_PC: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && scan_q) |=> (pc_inc || pc_dec)); // R9

endmodule

// File: tb/bracket_scan_ctrl_tb.sv
module bracket_scan_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       cell_zero = 1'b0;
  logic       pc_inc, pc_dec, depth_up, depth_down, scan_active, scan_back;
  logic [7:0] depth;

  always #5 clk = ~clk;

  bracket_scan_ctrl u_dut (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
    .cell_zero (cell_zero), .pc_inc (pc_inc), .pc_dec (pc_dec),
    .depth_up (depth_up), .depth_down (depth_down),
    .scan_active (scan_active), .scan_back (scan_back), .depth (depth)
  );

  typedef struct {
    logic [5:0] outs;
    logic [7:0] dep;
    int         due;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  logic       mdl_m = 1'b0;
  logic       mdl_d = 1'b0;
  logic [7:0] mdl_dep = 8'd0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the item that falls due this cycle
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [5:0] got;
      e = q.pop_front();
      got = {pc_inc, pc_dec, depth_up, depth_down, scan_active, scan_back};
      checks++;
      if (got !== e.outs || depth !== e.dep) begin
        errors++;
        $display("FAIL %s: outs=%b depth=%0d expected outs=%b depth=%0d",
                 e.tag, got, depth, e.outs, e.dep);
      end
    end
  end

  // driver: apply one command and queue its expected outcome
  task automatic step(input logic v, input logic [2:0] c, input logic z,
                      input string tag);
    exp_t e;
    logic pi, pd, du, dd, fm, fd, b;
    @(negedge clk);
    cmd_valid = v; cmd_code = c; cell_zero = z;
    pi = 0; pd = 0; du = 0; dd = 0; fm = 0; fd = 0;
    b = (mdl_dep == 8'd0);
    if (v) begin
      if (!mdl_m) begin
        if (c == 3'd6) begin pi = 1; fm = z; end
        else if (c == 3'd7) begin
          if (z) pi = 1; else begin pd = 1; fm = 1; fd = 1; end
        end
      end else if (!mdl_d) begin
        pi = 1;
        if (c == 3'd6) du = 1;
        else if (c == 3'd7) begin if (b) fm = 1; else dd = 1; end
      end else begin
        if (c == 3'd7) begin pd = 1; du = 1; end
        else if (c == 3'd6) begin
          if (b) begin pi = 1; fm = 1; fd = 1; end
          else begin pd = 1; dd = 1; end
        end else pd = 1;
      end
    end
    mdl_m = mdl_m ^ fm;
    mdl_d = mdl_d ^ fd;
    if (du) mdl_dep = mdl_dep + 8'd1;
    if (dd) mdl_dep = mdl_dep - 8'd1;
    e.outs = {pi, pd, du, dd, mdl_m, mdl_d};
    e.dep  = mdl_dep;
    e.due  = cyc + 1;
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({pc_inc, pc_dec, depth_up, depth_down, scan_active, scan_back} !== 6'b0
        || depth !== 8'd0) begin
      errors++;
      $display("FAIL R1: outs=%b depth=%0d expected outs=000000 depth=0",
               {pc_inc, pc_dec, depth_up, depth_down, scan_active, scan_back}, depth);
    end
    rst = 1'b0;

    step(0, 3'd6, 1, "R12");
    step(0, 3'd7, 0, "R12");
    for (int k = 0; k < 6; k++) step(1, 3'(k), k[0], "R10");
    step(1, 3'd6, 0, "R2");
    step(1, 3'd7, 1, "R2");
    // forward skip with nesting
    step(1, 3'd6, 1, "R3");
    step(1, 3'd0, 1, "R9");
    step(1, 3'd6, 0, "R5");
    step(1, 3'd6, 1, "R5");
    step(0, 3'd7, 0, "R12");
    step(1, 3'd7, 1, "R5");
    step(1, 3'd4, 0, "R9");
    step(1, 3'd7, 0, "R5");
    step(1, 3'd7, 1, "R6");
    step(1, 3'd1, 0, "R10");
    // backward repeat with nesting
    step(1, 3'd7, 0, "R4");
    step(1, 3'd2, 1, "R9");
    step(1, 3'd7, 1, "R7");
    step(1, 3'd5, 0, "R9");
    step(1, 3'd6, 1, "R7");
    step(1, 3'd6, 0, "R8");
    step(1, 3'd3, 1, "R10");
    // wrap of the depth counter
    step(1, 3'd6, 1, "R3");
    for (int k = 0; k < 256; k++) step(1, 3'd6, 0, "R11");
    step(1, 3'd7, 0, "R6");
    step(0, 3'd0, 0, "R12");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule